// File: doc/BRIEF.md
# Package Low-Power State Resolver

This block merges the idle requests of a set of cores and one graphics engine into a single package-level low-power state. Each core reports a requested state code. The graphics engine reports one code in the same encoding. From these, the block picks the shallowest depth the cores agree on. It then narrows that depth by four limits: the deepest state the platform permits, a software cap, a near-term constraint flag, and any pending memory traffic. The result is held in a register.

Alongside the state, the block drives three outputs. One asks for a last-level-cache flush. One says whether the cache contents remain valid. One is a single-cycle change marker. A power controller uses the registered state to sequence rails and clocks. It reads the flush and valid outputs to decide how to treat the shared cache.

Top module: `lps_resolver`

## Requirements
- R1: The outputs are registered and reflect the inputs one clock edge after they are applied. While reset is high and on release, the state is C0, flush is 0, cache-valid is 1 and the change marker is 0. Core and graphics codes are 0=C0, 1=C1, 2=C3, 3=C6, 4=C7. Package codes (state output, software cap, platform limit) are 0=C0, 1=C1/C1E, 2=C2, 3=C3, 4=C6, 5=C7.
- R2: If any core requests C0, or reports a code above 4, the package state is C0.
- R3: If every core is at C1 or deeper and at least one is at C1, the package state is C1 when auto-promotion is enabled and C0 when it is disabled.
- R4: If every core is at C3 or deeper and graphics is at C3 or deeper, the package state is the shallowest core request (C3, C6 or C7), limited by the platform permission.
- R5: If the cores are all at C3 or deeper but graphics requests below C3, the package state is at most C1.
- R6: While the near-term constraint flag is high, the package state is at most C2.
- R7: If a memory request is pending or the outstanding count is non-zero while the resolved state is C3 or deeper, the package state is C2. It returns to the deeper state one edge after both clear.
- R8: The software cap bounds the package state: cores deeper than C1 with a cap of C1 give C1.
- R9: Flush is high only in C6 when every core requests C7. It stays low if any core requests C6.
- R10: Cache-valid is low in C7 and while flush is high, and high in every other state, C3 included.
- R11: The change marker pulses for one cycle whenever the state changes, except on entry into C1, which is silent.
- R12: C7 is reached only when every core requests C7 and the platform permits C7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_i | input | NUM_CORES*3 | Per-core request codes, core 0 in the low bits |
| gfx_req_i | input | 3 | Graphics request code |
| sw_cap_i | input | 3 | Software depth cap, package code |
| auto_promo_i | input | 1 | Auto-promotion enable for C1 |
| plat_limit_i | input | 3 | Deepest package state the platform permits |
| near_term_i | input | 1 | Latency-tolerance or imminent-timer constraint |
| mem_pend_i | input | 1 | Memory request pending |
| mem_outst_i | input | CNT_W | Outstanding memory request count |
| pkg_state_o | output | 3 | Resolved package state code |
| llc_flush_o | output | 1 | Last-level-cache flush request |
| llc_valid_o | output | 1 | Cache contents remain valid |
| state_chg_o | output | 1 | One-cycle marker on a state change |

## Verification
Each of the four outputs is due exactly one rising edge after the inputs that produce it. This also covers the return from the memory-forced C2, which comes one edge after the pending flag and the count both clear. The driver applies each vector just after a falling edge and files its expected outputs under the cycle number of the next rising edge. The monitor compares them at the falling edge that follows that rising edge, so no check reads a value that is still settling. The expected change marker comes from the expected state of the previous vector, applying the silent-C1 rule.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int CODE_W = 3;

  // core / graphics request codes
  localparam logic [CODE_W-1:0] RQ_C0 = 3'd0;
  localparam logic [CODE_W-1:0] RQ_C1 = 3'd1;
  localparam logic [CODE_W-1:0] RQ_C3 = 3'd2;
  localparam logic [CODE_W-1:0] RQ_C6 = 3'd3;
  localparam logic [CODE_W-1:0] RQ_C7 = 3'd4;

  // package state codes, ordered by depth
  typedef logic [CODE_W-1:0] pstate_t;
  localparam pstate_t PK_C0 = 3'd0;
  localparam pstate_t PK_C1 = 3'd1;
  localparam pstate_t PK_C2 = 3'd2;
  localparam pstate_t PK_C3 = 3'd3;
  localparam pstate_t PK_C6 = 3'd4;
  localparam pstate_t PK_C7 = 3'd5;

  function automatic pstate_t pk_min(input pstate_t a, input pstate_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic pstate_t req_to_pk(input logic [CODE_W-1:0] rq);
    pstate_t r;
    case (rq)
      RQ_C1:   r = PK_C1;
      RQ_C3:   r = PK_C3;
      RQ_C6:   r = PK_C6;
      RQ_C7:   r = PK_C7;
      default: r = PK_C0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lps_core_merge.sv
module lps_core_merge
  import lps_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES*CODE_W-1:0] core_req_i,
  output logic                        any_active_o,
  output logic [CODE_W-1:0]           shallow_o,
  output logic                        all_c7_o
);
  logic [CODE_W-1:0] code [NUM_CORES];
  logic [NUM_CORES-1:0] bad;

  genvar g;
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_unpack
      assign code[g] = core_req_i[g*CODE_W +: CODE_W];
      assign bad[g]  = (code[g] == RQ_C0) || (code[g] > RQ_C7);
    end
  endgenerate

  always_comb begin
    shallow_o = RQ_C7;
    all_c7_o  = 1'b1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (code[i] < shallow_o) shallow_o = code[i];
      if (code[i] != RQ_C7)    all_c7_o  = 1'b0;
    end
  end

  assign any_active_o = |bad;
endmodule

// File: rtl/lps_depth_limit.sv
module lps_depth_limit
  import lps_pkg::*;
(
  input  logic              any_active_i,
  input  logic [CODE_W-1:0] shallow_i,
  input  logic [CODE_W-1:0] gfx_req_i,
  input  logic              auto_promo_i,
  input  pstate_t           plat_limit_i,
  input  pstate_t           sw_cap_i,
  input  logic              near_term_i,
  output pstate_t           base_o
);
  logic    gfx_deep;
  pstate_t cand;

  assign gfx_deep = (gfx_req_i >= RQ_C3) && (gfx_req_i <= RQ_C7);

  always_comb begin
    if (any_active_i) begin
      cand = PK_C0;
    end else if (shallow_i == RQ_C1) begin
      cand = auto_promo_i ? PK_C1 : PK_C0;
    end else if (!gfx_deep) begin
      cand = PK_C1;
    end else begin
      cand = req_to_pk(shallow_i);
      if (near_term_i) cand = pk_min(cand, PK_C2);
    end
    base_o = pk_min(pk_min(cand, plat_limit_i), sw_cap_i);
  end
endmodule

// File: rtl/lps_mem_guard.sv
module lps_mem_guard
  import lps_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  pstate_t           base_i,
  input  logic              all_c7_i,
  input  logic              mem_pend_i,
  input  logic [CNT_W-1:0]  mem_outst_i,
  output pstate_t           final_o,
  output logic              flush_o
);
  logic busy;
  logic hold;

  assign busy    = mem_pend_i || (mem_outst_i != '0);
  assign hold    = busy && (base_i >= PK_C3);
  assign final_o = hold ? PK_C2 : base_i;
  assign flush_o = !hold && (base_i == PK_C6) && all_c7_i;
endmodule

// File: rtl/lps_resolver.sv
module lps_resolver
  import lps_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES*CODE_W-1:0] core_req_i,
  input  logic [CODE_W-1:0]           gfx_req_i,
  input  logic [CODE_W-1:0]           sw_cap_i,
  input  logic                        auto_promo_i,
  input  logic [CODE_W-1:0]           plat_limit_i,
  input  logic                        near_term_i,
  input  logic                        mem_pend_i,
  input  logic [CNT_W-1:0]            mem_outst_i,
  output logic [CODE_W-1:0]           pkg_state_o,
  output logic                        llc_flush_o,
  output logic                        llc_valid_o,
  output logic                        state_chg_o
);
  logic              any_active;
  logic [CODE_W-1:0] shallow;
  logic              all_c7;
  pstate_t           base_st;
  pstate_t           next_st;
  logic              next_flush;
  logic              next_valid;

  lps_core_merge #(.NUM_CORES(NUM_CORES)) u_merge (
    .core_req_i   (core_req_i),
    .any_active_o (any_active),
    .shallow_o    (shallow),
    .all_c7_o     (all_c7)
  );

  lps_depth_limit u_limit (
    .any_active_i (any_active),
    .shallow_i    (shallow),
    .gfx_req_i    (gfx_req_i),
    .auto_promo_i (auto_promo_i),
    .plat_limit_i (plat_limit_i),
    .sw_cap_i     (sw_cap_i),
    .near_term_i  (near_term_i),
    .base_o       (base_st)
  );

  lps_mem_guard #(.CNT_W(CNT_W)) u_guard (
    .base_i      (base_st),
    .all_c7_i    (all_c7),
    .mem_pend_i  (mem_pend_i),
    .mem_outst_i (mem_outst_i),
    .final_o     (next_st),
    .flush_o     (next_flush)
  );

  assign next_valid = (next_st != PK_C7) && !next_flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkg_state_o <= PK_C0;
      llc_flush_o <= 1'b0;
      llc_valid_o <= 1'b1;
      state_chg_o <= 1'b0;
    end else begin
      pkg_state_o <= next_st;
      llc_flush_o <= next_flush;
      llc_valid_o <= next_valid;
      state_chg_o <= (next_st != pkg_state_o) && (next_st != PK_C1);
    end
  end
endmodule

// File: rtl/lps_resolver_chk.sv
module lps_resolver_chk
  import lps_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CORES*CODE_W-1:0] core_req_i,
  input logic [CODE_W-1:0]           sw_cap_i,
  input logic [CODE_W-1:0]           plat_limit_i,
  input logic                        near_term_i,
  input logic                        mem_pend_i,
  input logic [CODE_W-1:0]           pkg_state_o,
  input logic                        llc_flush_o,
  input logic                        llc_valid_o,
  input logic                        state_chg_o
);
  logic some_active;
  logic every_c7;

  always_comb begin
    some_active = 1'b0;
    every_c7    = 1'b1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core_req_i[i*CODE_W +: CODE_W] == RQ_C0 ||
          core_req_i[i*CODE_W +: CODE_W] > RQ_C7) some_active = 1'b1;
      if (core_req_i[i*CODE_W +: CODE_W] != RQ_C7) every_c7 = 1'b0;
    end
  end

  a_r2_active_core: assert property (@(posedge clk) disable iff (rst)
    some_active |=> pkg_state_o == PK_C0);

  a_r6_near_term: assert property (@(posedge clk) disable iff (rst)
    near_term_i |=> pkg_state_o <= PK_C2);

  a_r7_mem_shallow: assert property (@(posedge clk) disable iff (rst)
    mem_pend_i |=> pkg_state_o <= PK_C2);

  a_r8_sw_cap: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pkg_state_o <= $past(sw_cap_i));

  a_r9_flush_c6: assert property (@(posedge clk) disable iff (rst)
    llc_flush_o |-> pkg_state_o == PK_C6);

  a_r10_valid_c3: assert property (@(posedge clk) disable iff (rst)
    pkg_state_o == PK_C3 |-> llc_valid_o);

  a_r10_c7_invalid: assert property (@(posedge clk) disable iff (rst)
    pkg_state_o == PK_C7 |-> !llc_valid_o);

  a_r11_marker: assert property (@(posedge clk) disable iff (rst)
    state_chg_o |-> pkg_state_o != $past(pkg_state_o));

  a_r12_c7_gate: assert property (@(posedge clk) disable iff (rst)
    (!every_c7 || plat_limit_i < PK_C7) |=> pkg_state_o != PK_C7);
endmodule

bind lps_resolver lps_resolver_chk #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .core_req_i   (core_req_i),
  .sw_cap_i     (sw_cap_i),
  .plat_limit_i (plat_limit_i),
  .near_term_i  (near_term_i),
  .mem_pend_i   (mem_pend_i),
  .pkg_state_o  (pkg_state_o),
  .llc_flush_o  (llc_flush_o),
  .llc_valid_o  (llc_valid_o),
  .state_chg_o  (state_chg_o)
);

// File: tb/tb_lps_resolver.sv
`timescale 1ns/1ps
module tb_lps_resolver;
  localparam int NC = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC*3-1:0] core_req;
  logic [2:0]    gfx_req, sw_cap, plat_lim;
  logic          auto_en, near_term, mem_pend;
  logic [CW-1:0] mem_outst;
  logic [2:0]    st;
  logic          flush, valid, chg;

  always #2 clk = ~clk;

  lps_resolver #(.NUM_CORES(NC), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .core_req_i(core_req), .gfx_req_i(gfx_req),
    .sw_cap_i(sw_cap), .auto_promo_i(auto_en), .plat_limit_i(plat_lim),
    .near_term_i(near_term), .mem_pend_i(mem_pend), .mem_outst_i(mem_outst),
    .pkg_state_o(st), .llc_flush_o(flush), .llc_valid_o(valid), .state_chg_o(chg)
  );

  typedef struct {
    int         due;
    logic [2:0] st;
    logic       fl;
    logic       vl;
    logic       pu;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  int         n_vec = 0;
  logic [2:0] prev_exp = 3'd0;
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compare entries whose rising edge has passed
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "state",  int'(st),    int'(e.st));
      check(e.tag, "flush",  int'(flush), int'(e.fl));
      check(e.tag, "valid",  int'(valid), int'(e.vl));
      check(e.tag, "marker", int'(chg),   int'(e.pu));
    end
  end

  function automatic logic [NC*3-1:0] cores(input int a, input int b, input int c, input int d);
    return {d[2:0], c[2:0], b[2:0], a[2:0]};
  endfunction

  // driver: inputs already set; queue expectations, advance one cycle
  task automatic step(input logic [2:0] es, input logic ef, input logic ev, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.st  = es;
    e.fl  = ef;
    e.vl  = ev;
    e.pu  = (es != prev_exp) && (es != 3'd1);
    e.tag = tag;
    sb.push_back(e);
    prev_exp = es;
    n_vec++;
    @(negedge clk);
  endtask

  task automatic defaults();
    core_req  = cores(0, 0, 0, 0);
    gfx_req   = 3'd4;
    sw_cap    = 3'd5;
    plat_lim  = 3'd5;
    auto_en   = 1'b1;
    near_term = 1'b0;
    mem_pend  = 1'b0;
    mem_outst = '0;
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    check("R1", "reset state", int'(st), 0);
    check("R1", "reset flush", int'(flush), 0);
    check("R1", "reset valid", int'(valid), 1);
    check("R1", "reset marker", int'(chg), 0);
    rst = 1'b0;
    @(negedge clk);

    step(3'd0, 0, 1, "R2 all active");
    core_req = cores(1, 1, 1, 1);                    step(3'd1, 0, 1, "R3 C1 auto on, R11 silent");
    auto_en = 1'b0;                                  step(3'd0, 0, 1, "R3 C1 auto off");
    auto_en = 1'b1; core_req = cores(1, 4, 4, 4);    step(3'd1, 0, 1, "R3 mixed C1");
    core_req = cores(4, 4, 3, 2);                    step(3'd3, 0, 1, "R4 C3 valid R10");
    step(3'd3, 0, 1, "R11 hold no marker");
    core_req = cores(4, 3, 3, 4);                    step(3'd4, 0, 1, "R9 C6 core no flush");
    core_req = cores(4, 4, 4, 4); plat_lim = 3'd4;   step(3'd4, 1, 0, "R9 flush R10");
    plat_lim = 3'd5;                                 step(3'd5, 0, 0, "R12 C7");
    mem_pend = 1'b1;                                 step(3'd2, 0, 1, "R7 mem to C2");
    mem_pend = 1'b0; mem_outst = 8'd3;               step(3'd2, 0, 1, "R7 outstanding");
    mem_outst = '0;                                  step(3'd5, 0, 0, "R7 return");
    core_req = cores(3, 3, 3, 3); near_term = 1'b1;  step(3'd2, 0, 1, "R6 near-term");
    near_term = 1'b0; core_req = cores(4, 4, 4, 4); sw_cap = 3'd1;
                                                     step(3'd1, 0, 1, "R8 cap C1");
    sw_cap = 3'd5; core_req = cores(4, 4, 2, 4); plat_lim = 3'd3;
                                                     step(3'd3, 0, 1, "R4 plat C3");
    core_req = cores(2, 4, 4, 4); plat_lim = 3'd4;   step(3'd3, 0, 1, "R4 shallow C3");
    plat_lim = 3'd5; core_req = cores(4, 4, 4, 4); gfx_req = 3'd1;
                                                     step(3'd1, 0, 1, "R5 gfx shallow");
    gfx_req = 3'd4; core_req = cores(4, 6, 4, 4);    step(3'd0, 0, 1, "R2 bad code");
    core_req = cores(4, 4, 4, 4); plat_lim = 3'd4;   step(3'd4, 1, 0, "R12 plat C6");
    core_req = cores(1, 1, 1, 1); mem_pend = 1'b1;   step(3'd1, 0, 1, "R7 no effect in C1");
    mem_pend = 1'b0; core_req = cores(3, 3, 3, 3); plat_lim = 3'd5;
                                                     step(3'd4, 0, 1, "R4 C6");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule